// File: doc/BRIEF.md
# Dual Serial CRC Accumulator for a Serial Peripheral Port

This block keeps two running CRC values next to a serial shift register. One covers the bits the port sends out and the other covers the bits it samples in. Each accepted bit advances both accumulators in the same cycle. The update runs MSB-first through a linear feedback shift register, and the feedback taps come from a polynomial input that can change at run time.

A frame-size select sets the CRC width. When it is low the accumulators act as 8-bit CRCs: they use only the low byte of the polynomial and their upper byte reads zero. When it is high the full 16 bits take part, as in the usual CCITT-style CRC16.

Turning the enable on starts a fresh computation. The busy output stays high while a frame is only partly shifted in. Software should read the CRC values only when busy is low.

Top module: `spi_crc_dual`

## Requirements
- R1: After reset both CRC outputs are 0x0000 and busy is 0.
- R2: In a cycle where crcEnable goes from 0 to 1, both accumulators and the frame bit count are set to zero, and a bitValid in that same cycle is dropped. Both outputs read 0x0000 after that edge.
- R3: An accumulator changes only on a clock edge where bitValid and crcEnable are both 1. With either one low, both outputs keep their value.
- R4: In wide mode (wideFrame=1) each accepted bit does the following. The feedback is bit 15 XOR the data bit, the value is shifted left by one with a 0 shifted in, and when the feedback is 1 the shifted value is XORed with poly[15:0].
- R5: In narrow mode (wideFrame=0), bit 7 gives the feedback, only bits 7..0 are shifted, and poly[7:0] gives the taps. Bits 15..8 of both outputs read 0.
- R6: txCrc accumulates txBit only and rxCrc accumulates rxBit only. The two values are independent of each other.
- R7: busy is 1 from the first accepted bit of a frame until the frame's last bit (the 8th in narrow mode, the 16th in wide mode) is accepted. After that last bit busy is 0.
- R8: The outputs are registered. The effect of a bit accepted at one clock edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| crcEnable | input | 1 | CRC enable; a rising edge clears both CRCs |
| bitValid | input | 1 | Strobe: one serial bit is shifting this cycle |
| txBit | input | 1 | Outgoing serial bit |
| rxBit | input | 1 | Incoming serial bit |
| poly | input | 16 | Generator polynomial taps |
| wideFrame | input | 1 | 1 = 16-bit CRC, 0 = 8-bit CRC |
| txCrc | output | 16 | CRC over the transmitted bits |
| rxCrc | output | 16 | CRC over the received bits |
| busy | output | 1 | A frame is partly shifted |

## Verification
The assertions check four things on every cycle. A clear leaves the accumulators and busy at zero. An accumulator never moves without a step strobe. A narrow-mode step leaves the upper byte zero. The frame bit count stays inside the frame. Whether the CRC values are correct for a given polynomial and data stream, and whether the transmit and receive lanes stay independent, can only be shown by the bench. It compares both outputs against a bitwise software model over tabled frames in both widths, and it also uses two known CRC8 results.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  // strobes sent from the control to each datapath lane
  typedef struct packed {
    logic clear;
    logic step;
  } crcCtrl_t;
endpackage

// File: rtl/spi_crc_ctrl.sv
module spi_crc_ctrl
  import spi_crc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     crcEnable,
  input  logic     bitValid,
  input  logic     wideFrame,
  output crcCtrl_t ctl,
  output logic     busy
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_W - 1);

  logic             enPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;

  always_comb begin
    ctl.clear = crcEnable & ~enPrev;
    ctl.step  = bitValid & crcEnable & ~ctl.clear;
    lastIdx   = wideFrame ? WIDE_LAST : NARROW_LAST;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      bitCnt <= '0;
    end else begin
      enPrev <= crcEnable;
      if (ctl.clear)
        bitCnt <= '0;
      else if (ctl.step)
        bitCnt <= (bitCnt >= lastIdx) ? '0 : bitCnt + 1'b1;
    end
  end

  assign busy = (bitCnt != '0);

  // R2: a clear leaves the frame idle
  p_clear_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> !busy);
  // R7: the bit count never reaches the full frame size
  p_count_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CNT_W'(DATA_W));
  // R7: the last bit of a narrow frame ends busy
  p_narrow_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !wideFrame && bitCnt == NARROW_LAST) |=> !busy);
endmodule

// File: rtl/spi_crc_lane.sv
module spi_crc_lane
  import spi_crc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcCtrl_t          ctl,
  input  logic              dIn,
  input  logic              wideFrame,
  input  logic [DATA_W-1:0] poly,
  output logic [DATA_W-1:0] crcOut
);
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] crcQ;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] crcNext;
  logic              topBit;
  logic              feedback;

  always_comb begin
    topBit   = wideFrame ? crcQ[DATA_W-1] : crcQ[NARROW_W-1];
    feedback = topBit ^ dIn;
    shifted  = {crcQ[DATA_W-2:0], 1'b0};
    if (feedback) shifted = shifted ^ poly;
    crcNext  = wideFrame ? shifted : (shifted & NARROW_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          crcQ <= '0;
    else if (ctl.clear) crcQ <= '0;
    else if (ctl.step)  crcQ <= crcNext;
  end

  assign crcOut = wideFrame ? crcQ : (crcQ & NARROW_MASK);

  // R2: clear empties the accumulator
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (crcQ == '0));
  // R3: no step, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.step && !ctl.clear) |=> $stable(crcQ));
  // R5: a narrow step keeps the upper byte empty
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !wideFrame) |=> (crcQ[DATA_W-1:NARROW_W] == '0));
endmodule

// File: rtl/spi_crc_dual.sv
module spi_crc_dual
  import spi_crc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              crcEnable,
  input  logic              bitValid,
  input  logic              txBit,
  input  logic              rxBit,
  input  logic [DATA_W-1:0] poly,
  input  logic              wideFrame,
  output logic [DATA_W-1:0] txCrc,
  output logic [DATA_W-1:0] rxCrc,
  output logic              busy
);
  localparam int LANES = 2;

  crcCtrl_t          ctl;
  logic [LANES-1:0]  laneBit;
  logic [DATA_W-1:0] laneCrc [LANES];

  assign laneBit = {rxBit, txBit};

  spi_crc_ctrl #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .crcEnable(crcEnable), .bitValid(bitValid),
    .wideFrame(wideFrame), .ctl(ctl), .busy(busy)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    spi_crc_lane #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_lane (
      .clk(clk), .rstN(rstN), .ctl(ctl), .dIn(laneBit[g]),
      .wideFrame(wideFrame), .poly(poly), .crcOut(laneCrc[g])
    );
  end

  assign txCrc = laneCrc[0];
  assign rxCrc = laneCrc[1];
endmodule

// File: tb/spi_crc_dual_bench.sv
module spi_crc_dual_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        crcEnable = 1'b0, bitValid = 1'b0, txBit = 1'b0, rxBit = 1'b0;
  logic [15:0] poly = 16'h0007;
  logic        wideFrame = 1'b0;
  logic [15:0] txCrc, rxCrc;
  logic        busy;
  int checks = 0, errors = 0;
  logic [15:0] mTx, mRx;

  always #5 clk = ~clk;

  spi_crc_dual u_spi_crc_dual (.*);

  // {wide, poly, txData, rxData}
  localparam logic [48:0] VEC [8] = '{
    {1'b0, 16'h0007, 16'h00A5, 16'h003C},
    {1'b0, 16'h0031, 16'h00FF, 16'h0000},
    {1'b0, 16'h009B, 16'h0012, 16'h00ED},
    {1'b0, 16'hFF07, 16'h0080, 16'h0001},
    {1'b1, 16'h1021, 16'h3132, 16'hBEEF},
    {1'b1, 16'h8005, 16'hFFFF, 16'h1234},
    {1'b1, 16'h1021, 16'h0000, 16'h8001},
    {1'b1, 16'h3D65, 16'hC0DE, 16'h5A5A}
  };

  function automatic logic [15:0] model(input logic [15:0] c, input logic b,
                                        input logic wide, input logic [15:0] p);
    logic fb;
    logic [15:0] n;
    if (wide) begin
      fb = c[15] ^ b;
      n = {c[14:0], 1'b0} ^ (fb ? p : 16'h0);
    end else begin
      fb = c[7] ^ b;
      n = {8'h00, {c[6:0], 1'b0} ^ (fb ? p[7:0] : 8'h00)};
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge; registered result appears after the next posedge
  task automatic shiftBit(input logic t, input logic r, input logic v);
    @(negedge clk);
    txBit = t; rxBit = r; bitValid = v;
    if (v && crcEnable) begin
      mTx = model(mTx, t, wideFrame, poly);
      mRx = model(mRx, r, wideFrame, poly);
    end
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); crcEnable = 1'b0;
    @(negedge clk); crcEnable = 1'b1;
    @(negedge clk);
    mTx = '0; mRx = '0;
  endtask

  task automatic sendFrame(input logic [15:0] t, input logic [15:0] r);
    int n = wideFrame ? 16 : 8;
    for (int i = n - 1; i >= 0; i--) shiftBit(t[i], r[i], 1'b1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mTx = '0; mRx = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 txCrc", txCrc, 16'h0);
    check("R1 rxCrc", rxCrc, 16'h0);
    check("R1 busy", {15'b0, busy}, 16'h0);
    rstN = 1'b1;

    // table walk: two frames each, model comparison (R4, R5, R6, R7)
    foreach (VEC[k]) begin
      wideFrame = VEC[k][48]; poly = VEC[k][47:32];
      restart();
      sendFrame(VEC[k][31:16], VEC[k][15:0]);
      check(wideFrame ? "R4 tx frame1" : "R5 tx frame1", txCrc, mTx);
      check("R6 rx frame1", rxCrc, mRx);
      check("R7 busy after frame", {15'b0, busy}, 16'h0);
      sendFrame(VEC[k][15:0], ~VEC[k][31:16]);
      check(wideFrame ? "R4 tx frame2" : "R5 tx frame2", txCrc, mTx);
      check("R6 rx frame2", rxCrc, mRx);
      if (!wideFrame) check("R5 upper byte", {txCrc[15:8], rxCrc[15:8]}, 16'h0);
    end

    // known CRC8 results, poly 0x07: 0x01 -> 0x07, 0x80 -> 0x89
    wideFrame = 1'b0; poly = 16'h0007;
    restart();
    sendFrame(16'h0001, 16'h0080);
    check("R5 known 0x01", txCrc, 16'h0007);
    check("R6 known 0x80", rxCrc, 16'h0089);

    // R8 and R7: first bit visible right after its edge, busy mid-frame
    restart();
    shiftBit(1'b1, 1'b0, 1'b1);
    check("R8 first bit", txCrc, 16'h0007);
    check("R7 busy mid frame", {15'b0, busy}, 16'h1);

    // R3: bitValid low holds
    shiftBit(1'b1, 1'b1, 1'b0);
    check("R3 hold no strobe", txCrc, 16'h0007);
    // R3: enable low holds
    @(negedge clk); crcEnable = 1'b0;
    shiftBit(1'b1, 1'b1, 1'b1);
    check("R3 hold disabled tx", txCrc, 16'h0007);
    check("R3 hold disabled rx", rxCrc, 16'h0000);

    // R2: rising enable with a same-cycle bit clears and drops the bit
    @(negedge clk); crcEnable = 1'b1; bitValid = 1'b1; txBit = 1'b1; rxBit = 1'b1;
    @(negedge clk); bitValid = 1'b0;
    check("R2 tx clear", txCrc, 16'h0);
    check("R2 rx clear", rxCrc, 16'h0);
    check("R2 busy clear", {15'b0, busy}, 16'h0);

    // R7 wide: busy after 8 bits still high, low after 16
    wideFrame = 1'b1; poly = 16'h1021; mTx = '0; mRx = '0;
    for (int i = 0; i < 8; i++) shiftBit(1'b1, 1'b0, 1'b1);
    check("R7 wide busy at 8", {15'b0, busy}, 16'h1);
    for (int i = 0; i < 8; i++) shiftBit(1'b0, 1'b1, 1'b1);
    check("R7 wide idle at 16", {15'b0, busy}, 16'h0);
    check("R4 wide tx", txCrc, mTx);
    check("R4 wide rx", rxCrc, mRx);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule